// File: doc/BRIEF.md
# Dual-Channel ADC Output Formatter

This block sits behind a two-channel pipelined converter core. The core produces one sample word per channel per internal conversion, and both words of a pair come out at the same time. The formatter delays the pairs and presents them on the chip's output pins in one of four formats, chosen by two static strap inputs.

The two straps fix three things: whether the input clock runs at the conversion rate or at twice that rate, whether the two channels get separate buses or share one bus, and how the latch clock behaves. The block drives a complementary latch-clock pair that a receiving device uses to capture the data. When the two channels share one bus, the latch clock also tells the receiver which channel the current word belongs to.

An active-low enable releases every data and latch-clock pin to high impedance at once, with no clock involved. The pipeline keeps advancing while the pins are released. The straps are expected to change only while reset is asserted.

Top module: `adc_pair_formatter`

## Requirements
- R1: With `rate_sel`=0, or with `bus_sel`=1, the channel words are taken on alternate clock edges only. The first rising edge after reset release takes a word, and the edge after it takes none. With `rate_sel`=1 and `bus_sel`=0, the words are taken on every edge.
- R2: Two-bus format with `rate_sel`=0 (double-rate clock): a pair taken at edge k appears on `bus_a` (channel A) and `bus_b` (channel B) just after edge k+8.
- R3: Two-bus format with `rate_sel`=1 (clock at the conversion rate): a pair taken at edge k appears on `bus_a` and `bus_b` just after edge k+4.
- R4: Shared-bus format (`bus_sel`=1): the channel A word taken at edge k appears on `bus_a` just after edge k+8. The channel B word of the same pair follows just after edge k+9. The two channels keep alternating on the bus.
- R5: In the shared-bus format, `bus_b` is driven to all zeros.
- R6: With `rate_sel`=0, `lclk` is low after each edge that takes a word and high after each other edge. It is a square wave at half the clock rate, and its rising edge falls midway through each two-edge slot.
- R7: With `rate_sel`=1 and `bus_sel`=0, `lclk` is the inverted input clock.
- R8: With `rate_sel`=1 and `bus_sel`=1, `lclk` is high while a channel A word is on `bus_a` and low while a channel B word is there.
- R9: While the outputs are enabled, `lclk_n` is always the complement of `lclk`.
- R10: With `out_en_n` high, `bus_a`, `bus_b`, `lclk` and `lclk_n` are at high impedance immediately, without waiting for a clock edge. The pipeline keeps running, so the data seen after re-enable is the same as it would have been with the pins never released.
- R11: While `rst_n` is low, both buses read zero. `lclk` is low in every format except the one of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock (conversion rate or twice it) |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 1 | Clock-rate / latch-clock strap |
| bus_sel | input | 1 | 0 = two buses, 1 = shared bus |
| out_en_n | input | 1 | Active-low output enable, asynchronous |
| chan_a | input | 10 | Channel A sample word from the core |
| chan_b | input | 10 | Channel B sample word from the core |
| bus_a | output | 10 | Channel A bus, or the shared A/B bus |
| bus_b | output | 10 | Channel B bus |
| lclk | output | 1 | Latch clock |
| lclk_n | output | 1 | Complementary latch clock |

## Verification
Two pairs of functions can land in the same cycle. In the shared-bus formats, the edge that moves the bus from one channel to the other is also the edge where the channel-marking latch clock flips. The bench checks both the word and the clock level after every edge against its queue model, which tracks which pair and which channel is due on that edge. The enable is also dropped halfway between clock edges while the pipeline holds live data. The pins are judged released one time unit later, with no edge in between, and after re-enable the data must line up with the uninterrupted model.

// File: rtl/apf_pkg.sv
package apf_pkg;

    // Output format, encoded as {rate_sel, bus_sel}
    typedef enum logic [1:0] {
        FMT_DUAL_DIV    = 2'b00,
        FMT_SINGLE_SLOW = 2'b01,
        FMT_DUAL_FULL   = 2'b10,
        FMT_SINGLE_FAST = 2'b11
    } fmt_e;

    // True when the input clock runs at twice the conversion rate
    function automatic logic div_clock(input fmt_e f);
        return f != FMT_DUAL_FULL;
    endfunction

    function automatic logic is_single(input fmt_e f);
        return (f == FMT_SINGLE_SLOW) || (f == FMT_SINGLE_FAST);
    endfunction

endpackage

// File: rtl/apf_phase.sv
module apf_phase
    import apf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  fmt_e fmt,
    output logic slot_q,
    output logic take
);

    typedef struct packed {
        logic slot;
    } ph_t;

    ph_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.slot = ~st_q.slot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot_q = st_q.slot;
    assign take   = !div_clock(fmt) || !st_q.slot;

    // R1: with a divided clock a taking edge is never followed by another
    a_r1_take_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        (div_clock(fmt) && take) |=> !take);

endmodule

// File: rtl/apf_delay.sv
module apf_delay #(
    parameter int W        = 10,
    parameter int DEPTH    = 8,
    parameter int FAST_IDX = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic [W-1:0] fast_a,
    output logic [W-1:0] fast_b,
    output logic [W-1:0] slow_a,
    output logic [W-1:0] slow_b,
    output logic [W-1:0] late_b
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] a;
        logic [DEPTH-1:0][W-1:0] b;
        logic [W-1:0]            late;
    } line_t;

    line_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.a[0] = take ? in_a : st_q.a[0];
        st_d.b[0] = take ? in_b : st_q.b[0];
        for (int i = 1; i < DEPTH; i++) begin
            st_d.a[i] = st_q.a[i-1];
            st_d.b[i] = st_q.b[i-1];
        end
        st_d.late = st_q.b[DEPTH-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fast_a = st_q.a[FAST_IDX];
    assign fast_b = st_q.b[FAST_IDX];
    assign slow_a = st_q.a[DEPTH-1];
    assign slow_b = st_q.b[DEPTH-1];
    assign late_b = st_q.late;

endmodule

// File: rtl/apf_bus.sv
module apf_bus
    import apf_pkg::*;
#(
    parameter int W       = 10,
    parameter bit DB_ZERO = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  fmt_e         fmt,
    input  logic         slot,
    input  logic [W-1:0] fast_a,
    input  logic [W-1:0] fast_b,
    input  logic [W-1:0] slow_a,
    input  logic [W-1:0] slow_b,
    input  logic [W-1:0] late_b,
    output logic [W-1:0] da_q,
    output logic [W-1:0] db_q,
    output logic         a_slot_q
);

    typedef struct packed {
        logic [W-1:0] da;
        logic [W-1:0] db;
        logic         a_slot;
    } bus_t;

    bus_t st_d, st_q;
    logic [W-1:0] db_single;

    generate
        if (DB_ZERO) begin : g_db_zero
            assign db_single = '0;
        end else begin : g_db_hold
            assign db_single = st_q.db;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        unique case (fmt)
            FMT_DUAL_DIV: begin
                st_d.da     = slow_a;
                st_d.db     = slow_b;
                st_d.a_slot = 1'b0;
            end
            FMT_DUAL_FULL: begin
                st_d.da     = fast_a;
                st_d.db     = fast_b;
                st_d.a_slot = 1'b0;
            end
            default: begin
                st_d.a_slot = ~slot;
                st_d.da     = slot ? late_b : slow_a;
                st_d.db     = db_single;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign da_q     = st_q.da;
    assign db_q     = st_q.db;
    assign a_slot_q = st_q.a_slot;

    // R5: shared-bus format leaves the second bus at zero
    a_r5_db_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (is_single(fmt) && DB_ZERO) |=> (db_q == '0));

endmodule

// File: rtl/apf_latch.sv
module apf_latch
    import apf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  fmt_e fmt,
    input  logic slot,
    output logic lvl_q,
    output logic lclk_int
);

    typedef struct packed {
        logic lvl;
    } lc_t;

    lc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (fmt)
            FMT_DUAL_DIV, FMT_SINGLE_SLOW: st_d.lvl = slot;
            FMT_SINGLE_FAST:               st_d.lvl = ~slot;
            default:                       st_d.lvl = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_q    = st_q.lvl;
    assign lclk_int = (fmt == FMT_DUAL_FULL) ? ~clk : st_q.lvl;

endmodule

// File: rtl/adc_pair_formatter.sv
module adc_pair_formatter
    import apf_pkg::*;
#(
    parameter int W        = 10,
    parameter int LAT_SLOW = 8,
    parameter int LAT_FAST = 4,
    parameter bit DB_ZERO  = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rate_sel,
    input  logic         bus_sel,
    input  logic         out_en_n,
    input  logic [W-1:0] chan_a,
    input  logic [W-1:0] chan_b,
    output logic [W-1:0] bus_a,
    output logic [W-1:0] bus_b,
    output logic         lclk,
    output logic         lclk_n
);

    fmt_e         fmt;
    logic         slot, take;
    logic [W-1:0] fast_a, fast_b, slow_a, slow_b, late_b;
    logic [W-1:0] da_q, db_q;
    logic         a_slot_q, lvl_q, lclk_int;

    assign fmt = fmt_e'({rate_sel, bus_sel});

    apf_phase u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .fmt    (fmt),
        .slot_q (slot),
        .take   (take)
    );

    apf_delay #(
        .W        (W),
        .DEPTH    (LAT_SLOW),
        .FAST_IDX (LAT_FAST - 1)
    ) u_delay (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .in_a   (chan_a),
        .in_b   (chan_b),
        .fast_a (fast_a),
        .fast_b (fast_b),
        .slow_a (slow_a),
        .slow_b (slow_b),
        .late_b (late_b)
    );

    apf_bus #(
        .W       (W),
        .DB_ZERO (DB_ZERO)
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .fmt      (fmt),
        .slot     (slot),
        .fast_a   (fast_a),
        .fast_b   (fast_b),
        .slow_a   (slow_a),
        .slow_b   (slow_b),
        .late_b   (late_b),
        .da_q     (da_q),
        .db_q     (db_q),
        .a_slot_q (a_slot_q)
    );

    apf_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .fmt      (fmt),
        .slot     (slot),
        .lvl_q    (lvl_q),
        .lclk_int (lclk_int)
    );

    // Asynchronous pin release
    assign bus_a  = out_en_n ? {W{1'bz}} : da_q;
    assign bus_b  = out_en_n ? {W{1'bz}} : db_q;
    assign lclk   = out_en_n ? 1'bz : lclk_int;
    assign lclk_n = out_en_n ? 1'bz : ~lclk_int;

    // Edges since reset release, saturating; used only to qualify properties
    logic [3:0] age_d, age_q;

    always_comb begin
        age_d = age_q;
        if (age_q != 4'hF) age_d = age_q + 4'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    // R3: conversion-rate two-bus format shows channel A four edges after capture
    a_r3_fast_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == FMT_DUAL_FULL && LAT_FAST == 4 && age_q >= 4'd6) |-> (da_q == $past(chan_a, 5)));

    // R6: latch clock toggles on every edge with a divided clock
    a_r6_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (!rate_sel && age_q >= 4'd2) |=> (lvl_q != $past(lvl_q)));

    // R8: latch clock level marks the channel A word on the shared bus
    a_r8_marks_a: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == FMT_SINGLE_FAST) |-> (lvl_q == a_slot_q));

endmodule

// File: tb/adc_pair_formatter_tb.sv
module adc_pair_formatter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n, rate_sel, bus_sel, out_en_n;
    logic [9:0] chan_a, chan_b;
    wire  [9:0] bus_a, bus_b;
    wire        lclk, lclk_n;

    always #4 clk = ~clk;

    for (genvar i = 0; i < 10; i++) begin : g_pu
        pullup pu_a (bus_a[i]);
        pullup pu_b (bus_b[i]);
    end
    pullup pu_c  (lclk);
    pullup pu_cn (lclk_n);

    adc_pair_formatter dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (rate_sel),
        .bus_sel  (bus_sel),
        .out_en_n (out_en_n),
        .chan_a   (chan_a),
        .chan_b   (chan_b),
        .bus_a    (bus_a),
        .bus_b    (bus_b),
        .lclk     (lclk),
        .lclk_n   (lclk_n)
    );

    int         total = 0;
    int         bad   = 0;
    bit         finished = 1'b0;
    logic [9:0] cap_a [0:255];
    logic [9:0] cap_b [0:255];

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [9:0] hist(input int idx, input bit chan_b_sel);
        if (idx < 1) return 10'h000;
        return chan_b_sel ? cap_b[idx] : cap_a[idx];
    endfunction

    task automatic drive_words();
        chan_a = 10'($urandom % 1023);
        chan_b = 10'($urandom % 1023);
    endtask

    task automatic run_mode(input bit m, input bit s, input int cycles,
                            input int oe_from, input int oe_to);
        @(negedge clk);
        rst_n = 1'b0; rate_sel = m; bus_sel = s; out_en_n = 1'b0;
        drive_words();
        repeat (2) @(posedge clk);
        #2;
        chk("R11 bus_a", bus_a, 10'h000);
        chk("R11 bus_b", bus_b, 10'h000);
        if (!(m && !s)) chk("R11 lclk", {9'b0, lclk}, 10'h000);
        @(negedge clk);
        rst_n = 1'b1;
        drive_words();
        cap_a[0] = '0; cap_b[0] = '0;
        for (int n = 1; n <= cycles; n++) begin
            @(posedge clk);
            begin
                bit take;
                take = (m && !s) || (n % 2 == 1);
                cap_a[n] = take ? chan_a : cap_a[n-1];
                cap_b[n] = take ? chan_b : cap_b[n-1];
            end
            #2;
            if (out_en_n) begin
                chk("R10 bus_a released", bus_a, 10'h3FF);
                chk("R10 bus_b released", bus_b, 10'h3FF);
                chk("R10 lclk pair released", {8'b0, lclk, lclk_n}, 10'h003);
            end else begin
                if (!s) begin
                    int lat;
                    lat = m ? 4 : 8;
                    chk(m ? "R3 bus_a" : "R1 R2 bus_a", bus_a, hist(n - lat, 1'b0));
                    chk(m ? "R3 bus_b" : "R1 R2 bus_b", bus_b, hist(n - lat, 1'b1));
                    if (m) chk("R7 lclk high phase", {9'b0, lclk}, 10'h000);
                    else   chk("R6 lclk", {9'b0, lclk}, (n % 2 == 1) ? 10'h000 : 10'h001);
                end else begin
                    if (n % 2 == 1) chk("R1 R4 bus_a A word", bus_a, hist(n - 8, 1'b0));
                    else            chk("R4 bus_a B word", bus_a, hist(n - 9, 1'b1));
                    chk("R5 bus_b zero", bus_b, 10'h000);
                    if (m) chk("R8 lclk channel mark", {9'b0, lclk}, (n % 2 == 1) ? 10'h001 : 10'h000);
                    else   chk("R6 lclk", {9'b0, lclk}, (n % 2 == 1) ? 10'h000 : 10'h001);
                end
                chk("R9 lclk_n", {9'b0, lclk_n}, {9'b0, ~lclk});
            end
            @(negedge clk);
            drive_words();
            if (n == oe_from) begin
                out_en_n = 1'b1;
                #1;
                chk("R10 async bus_a", bus_a, 10'h3FF);
                chk("R10 async lclk pair", {8'b0, lclk, lclk_n}, 10'h003);
            end
            if (n == oe_to) out_en_n = 1'b0;
            if (m && !s && !out_en_n) begin
                #1;
                chk("R7 lclk low phase", {9'b0, lclk}, 10'h001);
            end
        end
    endtask

    initial begin
        rst_n = 1'b0; rate_sel = 1'b0; bus_sel = 1'b0; out_en_n = 1'b0;
        chan_a = '0; chan_b = '0;
        run_mode(1'b0, 1'b0, 70, 30, 34);
        run_mode(1'b1, 1'b0, 50, 20, 23);
        run_mode(1'b0, 1'b1, 70, 0, 0);
        run_mode(1'b1, 1'b1, 70, 41, 44);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R11 act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule